// File: doc/BRIEF.md
# Endpoint Buffer RAM Allocator

This block hands out space in a shared, word-addressed buffer RAM while a USB device controller brings endpoints into service one at a time during operation. Each request carries a physical endpoint index, a maximum packet size in bytes and a flag that selects single or double buffering. The block works out how many words the endpoint needs and returns the base word address of that endpoint's area. It also keeps a running count of occupied words.

Every buffer of an endpoint holds the packet payload rounded up to whole 32-bit words, plus one header word that records the received length. A double-buffered endpoint takes twice that amount. The lowest words of the RAM are kept for the buffer pointer table, so endpoint areas are placed after it. They are packed back to back in the order in which they are requested. A request that does not fit is refused and changes nothing. A synchronous clear empties the allocation again.

Top module: `ep_ram_allocator`

## Requirements
- R1: After reset, and in the cycle after a clear, `used_o` is 32, `free_o` is 992, and `ack_o` and `ovf_o` are 0.
- R2: With `req_dbl_i` = 0 (single buffer), the granted size `words_o` equals floor((`req_mps_i` + 3) / 4) + 1. A packet size of 0 therefore gives 1 word.
- R3: With `req_dbl_i` = 1 (double buffer), `words_o` equals 2 × (floor((`req_mps_i` + 3) / 4) + 1).
- R4: `base_o` equals `used_o` as it stood before the request. After an accepted request, `used_o` grows by exactly `words_o`, so areas are packed in request order.
- R5: `ack_o` is high for exactly the one cycle after a cycle in which `req_valid_i` was high and `clr_i` low. In every other cycle it is low.
- R6: A request for which `used_o` + `words_o` would exceed 1024 is acknowledged with `ovf_o` = 1 for that one cycle, and `used_o` and `free_o` stay unchanged.
- R7: A request that brings `used_o` to exactly 1024 is accepted with `ovf_o` = 0.
- R8: `free_o` always equals 1024 − `used_o`.
- R9: When `clr_i` and `req_valid_i` are high in the same cycle, the clear wins. The request is dropped with no acknowledge, and `used_o` returns to 32.
- R10: `ack_ep_o` returns the endpoint index of the request being acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_i | input | 1 | Synchronous clear of all allocations |
| req_valid_i | input | 1 | Request strobe, one cycle per request |
| req_ep_i | input | 5 | Physical endpoint index |
| req_mps_i | input | 10 | Maximum packet size in bytes (0 to 1023) |
| req_dbl_i | input | 1 | 0 = single buffer, 1 = double buffer |
| ack_o | output | 1 | Result valid, one cycle after the request |
| ack_ep_o | output | 5 | Endpoint index of the acknowledged request |
| base_o | output | 11 | Base word address granted |
| words_o | output | 11 | Words the endpoint needs |
| ovf_o | output | 1 | Request refused because the RAM would overflow |
| used_o | output | 11 | Words currently occupied, including the reserved area |
| free_o | output | 11 | Words still available |

## Verification
A clear and a new request can arrive in the same cycle, and so can a request and a full or nearly full RAM. The bench provokes the first case directly: it raises `clr_i` together with `req_valid_i`, both in a directed step and at random points during random traffic. It then expects no acknowledge and a total of 32 words. For the second case, it fills the RAM to exactly 1024 words with chosen packet sizes, then sends one request of size 0 that must be refused. Random requests are generated until refusals occur, and each refusal is judged against a bench model of the running total.

// File: rtl/ep_alloc_pkg.sv
package ep_alloc_pkg;

  localparam int DEF_RAM_WORDS = 1024;
  localparam int DEF_RSV_WORDS = 32;
  localparam int DEF_MPS_W     = 10;
  localparam int DEF_EP_W      = 5;

  typedef enum logic {
    BUF_SINGLE = 1'b0,
    BUF_DOUBLE = 1'b1
  } buf_mode_e;

endpackage

// File: rtl/ep_size_calc.sv
module ep_size_calc #(
  parameter int MPS_W = 10,
  parameter int WD_W  = MPS_W + 1
) (
  input  logic [MPS_W-1:0] mps_i,
  input  logic             dbl_i,
  output logic [WD_W-1:0]  words_o
);
  import ep_alloc_pkg::*;

  localparam int PAY_W = MPS_W + 1;

  logic [PAY_W-1:0] rounded;
  logic [WD_W-1:0]  per_buf;

  always_comb begin
    rounded = (PAY_W'(mps_i) + PAY_W'(3)) >> 2;
    per_buf = WD_W'(rounded) + WD_W'(1);
    if (buf_mode_e'(dbl_i) == BUF_DOUBLE)
      words_o = per_buf << 1;
    else
      words_o = per_buf;
  end

endmodule

// File: rtl/ep_alloc_ctrl.sv
module ep_alloc_ctrl #(
  parameter int RAM_WORDS = 1024,
  parameter int RSV_WORDS = 32,
  parameter int EP_W      = 5,
  parameter int WD_W      = 11,
  parameter int CNT_W     = $clog2(RAM_WORDS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             req_i,
  input  logic [EP_W-1:0]  ep_i,
  input  logic [WD_W-1:0]  words_i,
  output logic             ack_o,
  output logic [EP_W-1:0]  ack_ep_o,
  output logic [CNT_W-1:0] base_o,
  output logic [WD_W-1:0]  words_o,
  output logic             ovf_o,
  output logic [CNT_W-1:0] used_o,
  output logic [CNT_W-1:0] free_o
);

  localparam int SUM_W = ((CNT_W > WD_W) ? CNT_W : WD_W) + 1;

  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] left;
  logic             fits;

  always_comb begin
    sum  = SUM_W'(used_o) + SUM_W'(words_i);
    fits = (sum <= SUM_W'(RAM_WORDS));
    left = SUM_W'(RAM_WORDS) - sum;
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      used_o   <= CNT_W'(RSV_WORDS);
      free_o   <= CNT_W'(RAM_WORDS - RSV_WORDS);
      ack_o    <= 1'b0;
      ovf_o    <= 1'b0;
      ack_ep_o <= '0;
      base_o   <= '0;
      words_o  <= '0;
    end else begin
      ack_o <= req_i;
      ovf_o <= req_i && !fits;
      if (req_i) begin
        ack_ep_o <= ep_i;
        base_o   <= used_o;
        words_o  <= words_i;
        if (fits) begin
          used_o <= sum[CNT_W-1:0];
          free_o <= left[CNT_W-1:0];
        end
      end
    end
  end

  // R8
  free_sum_chk: assert property (@(posedge clk) disable iff (rst)
    (SUM_W'(used_o) + SUM_W'(free_o)) == SUM_W'(RAM_WORDS));

  // R6
  used_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (used_o <= CNT_W'(RAM_WORDS)) && (used_o >= CNT_W'(RSV_WORDS)));

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_o && ovf_o) |-> (used_o == $past(used_o)));

  // R4
  pack_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_o && !ovf_o) |-> (SUM_W'(used_o) == SUM_W'(base_o) + SUM_W'(words_o)));

  // R5
  ack_cause_chk: assert property (@(posedge clk) disable iff (rst)
    ack_o |-> $past(req_i && !clr_i));

  // R9
  clr_wins_chk: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (!ack_o && used_o == CNT_W'(RSV_WORDS)));

endmodule

// File: rtl/ep_ram_allocator.sv
module ep_ram_allocator #(
  parameter int RAM_WORDS = ep_alloc_pkg::DEF_RAM_WORDS,
  parameter int RSV_WORDS = ep_alloc_pkg::DEF_RSV_WORDS,
  parameter int MPS_W     = ep_alloc_pkg::DEF_MPS_W,
  parameter int EP_W      = ep_alloc_pkg::DEF_EP_W,
  parameter int WD_W      = MPS_W + 1,
  parameter int CNT_W     = $clog2(RAM_WORDS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             req_valid_i,
  input  logic [EP_W-1:0]  req_ep_i,
  input  logic [MPS_W-1:0] req_mps_i,
  input  logic             req_dbl_i,
  output logic             ack_o,
  output logic [EP_W-1:0]  ack_ep_o,
  output logic [CNT_W-1:0] base_o,
  output logic [WD_W-1:0]  words_o,
  output logic             ovf_o,
  output logic [CNT_W-1:0] used_o,
  output logic [CNT_W-1:0] free_o
);

  logic [WD_W-1:0] need_words;

  ep_size_calc #(
    .MPS_W (MPS_W),
    .WD_W  (WD_W)
  ) u_size (
    .mps_i   (req_mps_i),
    .dbl_i   (req_dbl_i),
    .words_o (need_words)
  );

  ep_alloc_ctrl #(
    .RAM_WORDS (RAM_WORDS),
    .RSV_WORDS (RSV_WORDS),
    .EP_W      (EP_W),
    .WD_W      (WD_W),
    .CNT_W     (CNT_W)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .clr_i    (clr_i),
    .req_i    (req_valid_i),
    .ep_i     (req_ep_i),
    .words_i  (need_words),
    .ack_o    (ack_o),
    .ack_ep_o (ack_ep_o),
    .base_o   (base_o),
    .words_o  (words_o),
    .ovf_o    (ovf_o),
    .used_o   (used_o),
    .free_o   (free_o)
  );

  // R3
  dbl_even_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_o && $past(req_dbl_i)) |-> (words_o[0] == 1'b0 && words_o >= WD_W'(2)));

endmodule

// File: tb/tb_ep_ram_allocator.sv
module tb_ep_ram_allocator;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clr_i = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [4:0]  req_ep_i = '0;
  logic [9:0]  req_mps_i = '0;
  logic        req_dbl_i = 1'b0;
  logic        ack_o;
  logic [4:0]  ack_ep_o;
  logic [10:0] base_o;
  logic [10:0] words_o;
  logic        ovf_o;
  logic [10:0] used_o;
  logic [10:0] free_o;

  int checks = 0;
  int failures = 0;
  int tot = 32;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ep_ram_allocator dut (
    .clk(clk), .rst(rst), .clr_i(clr_i), .req_valid_i(req_valid_i),
    .req_ep_i(req_ep_i), .req_mps_i(req_mps_i), .req_dbl_i(req_dbl_i),
    .ack_o(ack_o), .ack_ep_o(ack_ep_o), .base_o(base_o), .words_o(words_o),
    .ovf_o(ovf_o), .used_o(used_o), .free_o(free_o)
  );

  function automatic int calc_words(int mps, bit dbl);
    int per;
    per = (mps + 3) / 4 + 1;
    return dbl ? 2 * per : per;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(bit v, bit c, int ep, int mps, bit dbl);
    int w;
    bit eovf;
    int ebase;
    req_valid_i = v;
    clr_i       = c;
    req_ep_i    = 5'(ep);
    req_mps_i   = 10'(mps);
    req_dbl_i   = dbl;
    w     = calc_words(mps, dbl);
    ebase = tot;
    eovf  = (tot + w) > 1024;
    @(posedge clk);
    @(negedge clk);
    req_valid_i = 1'b0;
    clr_i       = 1'b0;
    if (c) begin
      tot = 32;
      chk("R9", "ack", int'(ack_o), 0);
      chk("R9", "used", int'(used_o), 32);
      chk("R1", "free", int'(free_o), 992);
    end else if (v) begin
      chk("R5", "ack", int'(ack_o), 1);
      chk(dbl ? "R3" : "R2", "words", int'(words_o), w);
      chk("R4", "base", int'(base_o), ebase);
      chk(eovf ? "R6" : "R7", "ovf", int'(ovf_o), int'(eovf));
      chk("R10", "ep", int'(ack_ep_o), ep);
      if (!eovf) tot = tot + w;
      chk(eovf ? "R6" : "R4", "used", int'(used_o), tot);
      chk("R8", "free", int'(free_o), 1024 - tot);
    end else begin
      chk("R5", "idle ack", int'(ack_o), 0);
      chk("R8", "idle free", int'(free_o), 1024 - tot);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h1234abcd;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1", "used", int'(used_o), 32);
    chk("R1", "free", int'(free_o), 992);
    chk("R1", "ack", int'(ack_o), 0);
    chk("R1", "ovf", int'(ovf_o), 0);

    // Directed packing and size corners
    step(1, 0, 1, 0, 0);      // R2 size 0 -> 1 word
    step(0, 0, 0, 0, 0);
    step(1, 0, 2, 64, 1);     // R3 34 words
    step(1, 0, 3, 1, 0);      // R2 2 words
    step(1, 0, 31, 1023, 1);  // R3 514 words -> 583
    step(1, 0, 4, 1023, 1);   // R6 refused
    step(1, 0, 5, 1023, 0);   // 257 -> 840
    step(1, 0, 6, 729, 0);    // R7 184 -> 1024 exact
    chk("R7", "full used", int'(used_o), 1024);
    step(1, 0, 7, 0, 0);      // R6 one word refused
    step(0, 1, 0, 0, 0);      // R1 clear
    chk("R1", "ovf after clr", int'(ovf_o), 0);
    step(1, 0, 8, 4, 0);
    step(1, 1, 9, 100, 1);    // R9 clear beats request
    step(1, 0, 10, 5, 1);     // base back at 32

    // Random traffic with occasional clears and idle cycles
    for (int i = 0; i < 600; i++) begin
      int r;
      r = int'($urandom_range(0, 19));
      if (r == 0)
        step(1, 1, int'($urandom_range(0, 31)), int'($urandom_range(0, 1023)), 1'($urandom_range(0, 1)));
      else if (r == 1)
        step(0, 1, 0, 0, 0);
      else if (r < 4)
        step(0, 0, 0, 0, 0);
      else
        step(1, 0, int'($urandom_range(0, 31)), int'($urandom_range(0, 1023)), 1'($urandom_range(0, 1)));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule